// File: doc/BRIEF.md
# Single and Double Register Shift Unit

This block is the shift execution unit of a 32-bit processor datapath. A single-cycle strobe hands it one of three things: a single register value, an even/odd register pair joined into a 64-bit operand, or a word to rotate. It also receives a 5-bit shift count, a 2-bit kind code and the current condition codes. One clock later the unit presents the shifted word or words, the new condition codes, an overflow flag and a trap request with its cause, and it marks them with a done pulse. These outputs stay in place until the next strobe. The unit does not hold the register file or the trap sequencer. The surrounding pipeline reads the register operands, writes the results back and acts on the trap request.

Arithmetic left shifts keep the sign bit fixed. When any bit that passes through the sign position differs from the original sign, the shift overflows. If the arithmetic exception enable is set, that overflow turns into a trap request. A pair shift that names an odd base register is rejected with an address specification trap and changes nothing else.

Top module: `shx_unit`

## Requirements
- R1: `kind_i` selects the operation: 2'b00 arithmetic right, 2'b01 logical right, 2'b10 arithmetic left, 2'b11 logical left. `count_i` gives 0 to 31 positions.
- R2: An arithmetic right shift fills vacated high bits with the original sign. The sign is bit 31 of `op_hi_i` in single mode and bit 63 of the pair value in double mode.
- R3: An arithmetic left shift flags overflow if, at any one-position step, the bit entering the sign position differs from the original sign. The result keeps the original sign bit.
- R4: After an arithmetic left shift `cc_o` is cleared, except `cc_o[3]` (CC1), which equals the overflow flag.
- R5: A trap request with cause 2'b01 (arithmetic) is raised when overflow occurs and `aexp_en_i` is high. Without overflow, or with the enable low, no arithmetic trap is raised.
- R6: In double mode the operand is {`op_hi_i`, `op_lo_i`}, with the even register as the high word. The result splits the same way into `res_hi_o`/`res_lo_o`. In single mode `res_lo_o` is zero.
- R7: A double shift with `reg_odd_i` high does not execute. Results and `cc_o` keep their previous values, `ovf_o` is 0 and a trap request with cause 2'b10 (address specification) is raised.
- R8: With `rot_i` high the unit rotates `op_hi_i` as one word. `kind_i[1]` = 1 selects left, where bit 31 wraps into bit 0, and 0 selects right, where bit 0 wraps into bit 31. `dbl_i` and `reg_odd_i` are ignored, and `res_lo_o` is zero.
- R9: Logical shifts, arithmetic right shifts and rotates copy `cc_i` to `cc_o` unchanged, never flag overflow and raise no trap.
- R10: A shift count of zero returns the operand unchanged, with no overflow and no trap.
- R11: `done_o` pulses for exactly the cycle after a `valid_i` strobe. All result, code and trap outputs hold until the next strobe. After reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Single-cycle operation strobe |
| kind_i | input | 2 | Shift kind code (R1); bit 1 also selects the rotate direction |
| count_i | input | 5 | Shift count |
| dbl_i | input | 1 | Register-pair (64-bit) mode |
| rot_i | input | 1 | Circular rotate select |
| reg_odd_i | input | 1 | Low bit of the named base register |
| aexp_en_i | input | 1 | Arithmetic exception trap enable |
| cc_i | input | 4 | Current condition codes, bit 3 is CC1 |
| op_hi_i | input | 32 | Single operand, or even (high) register of the pair |
| op_lo_i | input | 32 | Odd (low) register of the pair |
| res_hi_o | output | 32 | Result word, or high word of the pair result |
| res_lo_o | output | 32 | Low word of the pair result |
| cc_o | output | 4 | Updated condition codes |
| ovf_o | output | 1 | Overflow flag |
| trap_req_o | output | 1 | Trap request |
| trap_cause_o | output | 2 | 00 none, 01 arithmetic, 10 address specification |
| done_o | output | 1 | Result-valid pulse |

## Verification
The bench builds the unit with its default word width of 32. The pair path is therefore a full 64-bit shifter, and the 5-bit count reaches its maximum of 31. With these values a pair shift moves bits across the word boundary in both directions, and a single-word overflow can come from the step farthest from the sign. Counts of zero and 31, an overflow found only at the last step, and the sign of a pair taken from the high word are all reachable and are driven.

// File: rtl/shx_pkg.sv
package shx_pkg;
  typedef enum logic [1:0] {
    KIND_SRA = 2'b00,
    KIND_SRL = 2'b01,
    KIND_SLA = 2'b10,
    KIND_SLL = 2'b11
  } shx_kind_e;

  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'b00,
    CAUSE_ARITH = 2'b01,
    CAUSE_ADDR  = 2'b10
  } shx_cause_e;

  localparam int CC_W = 4;
endpackage

// File: rtl/shx_arith_shift.sv
module shx_arith_shift #(
  parameter int W     = 32,
  parameter int CNT_W = 5
) (
  input  logic [W-1:0]       data_i,
  input  logic [CNT_W-1:0]   cnt_i,
  input  shx_pkg::shx_kind_e kind_i,
  output logic [W-1:0]       res_o,
  output logic               ovf_o
);
  import shx_pkg::*;

  logic         sgn;
  logic [W-1:0] shl, shr_l, shr_a;
  logic [W-1:0] step_diff;

  assign sgn   = data_i[W-1];
  assign shl   = data_i << cnt_i;
  assign shr_l = data_i >> cnt_i;
  assign shr_a = W'($signed(data_i) >>> cnt_i);

  // step i moves bit W-1-i into the sign position
  assign step_diff[0] = 1'b0;
  for (genvar i = 1; i < W; i++) begin : g_step
    assign step_diff[i] = (int'(cnt_i) >= i) && (data_i[W-1-i] != sgn);
  end

  always_comb begin
    res_o = data_i;
    ovf_o = 1'b0;
    unique case (kind_i)
      KIND_SRA: res_o = shr_a;
      KIND_SRL: res_o = shr_l;
      KIND_SLA: begin
        res_o = {sgn, shl[W-2:0]};
        ovf_o = |step_diff;
      end
      KIND_SLL: res_o = shl;
      default:  res_o = data_i;
    endcase
  end
endmodule

// File: rtl/shx_rotate.sv
module shx_rotate #(
  parameter int W     = 32,
  parameter int CNT_W = 5
) (
  input  logic [W-1:0]     data_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             left_i,
  output logic [W-1:0]     res_o
);
  localparam int SW = CNT_W + 1;

  logic [SW-1:0] back;
  logic [W-1:0]  rot_l, rot_r;

  assign back  = SW'(W) - SW'(cnt_i);
  assign rot_l = (data_i << cnt_i) | (data_i >> back);
  assign rot_r = (data_i >> cnt_i) | (data_i << back);
  assign res_o = left_i ? rot_l : rot_r;
endmodule

// File: rtl/shx_unit.sv
module shx_unit #(
  parameter int WORD_W = 32,
  parameter int CNT_W  = $clog2(WORD_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [1:0]        kind_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              dbl_i,
  input  logic              rot_i,
  input  logic              reg_odd_i,
  input  logic              aexp_en_i,
  input  logic [3:0]        cc_i,
  input  logic [WORD_W-1:0] op_hi_i,
  input  logic [WORD_W-1:0] op_lo_i,
  output logic [WORD_W-1:0] res_hi_o,
  output logic [WORD_W-1:0] res_lo_o,
  output logic [3:0]        cc_o,
  output logic              ovf_o,
  output logic              trap_req_o,
  output logic [1:0]        trap_cause_o,
  output logic              done_o
);
  import shx_pkg::*;

  localparam int DBL_W = 2 * WORD_W;

  shx_kind_e          kind;
  logic [WORD_W-1:0]  sgl_res, rot_res;
  logic [DBL_W-1:0]   dbl_res;
  logic               sgl_ovf, dbl_ovf;
  logic               addr_fault, arith_left;
  logic [WORD_W-1:0]  nxt_hi, nxt_lo;
  logic               nxt_ovf;
  logic [CC_W-1:0]    nxt_cc;
  shx_cause_e         nxt_cause;

  assign kind = shx_kind_e'(kind_i);

  shx_arith_shift #(.W(WORD_W), .CNT_W(CNT_W)) u_sgl (
    .data_i (op_hi_i),
    .cnt_i  (count_i),
    .kind_i (kind),
    .res_o  (sgl_res),
    .ovf_o  (sgl_ovf)
  );

  shx_arith_shift #(.W(DBL_W), .CNT_W(CNT_W)) u_dbl (
    .data_i ({op_hi_i, op_lo_i}),
    .cnt_i  (count_i),
    .kind_i (kind),
    .res_o  (dbl_res),
    .ovf_o  (dbl_ovf)
  );

  shx_rotate #(.W(WORD_W), .CNT_W(CNT_W)) u_rot (
    .data_i (op_hi_i),
    .cnt_i  (count_i),
    .left_i (kind_i[1]),
    .res_o  (rot_res)
  );

  assign addr_fault = dbl_i && !rot_i && reg_odd_i;
  assign arith_left = !rot_i && (kind == KIND_SLA);

  always_comb begin
    if (rot_i) begin
      nxt_hi  = rot_res;
      nxt_lo  = '0;
      nxt_ovf = 1'b0;
    end else if (dbl_i) begin
      nxt_hi  = dbl_res[DBL_W-1:WORD_W];
      nxt_lo  = dbl_res[WORD_W-1:0];
      nxt_ovf = dbl_ovf;
    end else begin
      nxt_hi  = sgl_res;
      nxt_lo  = '0;
      nxt_ovf = sgl_ovf;
    end
    nxt_cc = arith_left ? {nxt_ovf, 3'b000} : cc_i;
    if (addr_fault)                nxt_cause = CAUSE_ADDR;
    else if (nxt_ovf && aexp_en_i) nxt_cause = CAUSE_ARITH;
    else                           nxt_cause = CAUSE_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_hi_o     <= '0;
      res_lo_o     <= '0;
      cc_o         <= '0;
      ovf_o        <= 1'b0;
      trap_req_o   <= 1'b0;
      trap_cause_o <= CAUSE_NONE;
      done_o       <= 1'b0;
    end else begin
      done_o <= valid_i;
      if (valid_i) begin
        trap_cause_o <= nxt_cause;
        trap_req_o   <= (nxt_cause != CAUSE_NONE);
        if (addr_fault) begin
          ovf_o <= 1'b0;
        end else begin
          res_hi_o <= nxt_hi;
          res_lo_o <= nxt_lo;
          cc_o     <= nxt_cc;
          ovf_o    <= nxt_ovf;
        end
      end
    end
  end
endmodule

// File: rtl/shx_unit_chk.sv
module shx_unit_chk #(
  parameter int WORD_W = 32,
  parameter int CNT_W  = $clog2(WORD_W)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [1:0]        kind_i,
  input logic [CNT_W-1:0]  count_i,
  input logic              dbl_i,
  input logic              rot_i,
  input logic              reg_odd_i,
  input logic              aexp_en_i,
  input logic [3:0]        cc_i,
  input logic [WORD_W-1:0] op_hi_i,
  input logic [WORD_W-1:0] res_hi_o,
  input logic [WORD_W-1:0] res_lo_o,
  input logic [3:0]        cc_o,
  input logic              ovf_o,
  input logic              trap_req_o,
  input logic [1:0]        trap_cause_o,
  input logic              done_o
);
  logic fault;
  assign fault = dbl_i && !rot_i && reg_odd_i;

  // R11
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> done_o);
  // R11
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !done_o);
  // R11
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(res_hi_o) && $stable(res_lo_o) && $stable(cc_o)
                 && $stable(trap_req_o) && $stable(ovf_o));
  // R7
  addr_trap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && fault |=> trap_req_o && trap_cause_o == 2'b10 && !ovf_o
                         && $stable(res_hi_o) && $stable(res_lo_o) && $stable(cc_o));
  // R9
  cc_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !fault && (rot_i || kind_i != 2'b10) |=> cc_o == $past(cc_i) && !ovf_o && !trap_req_o);
  // R4
  cc1_ovf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> cc_o == 4'b1000);
  // R5
  no_trap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !fault && !aexp_en_i |=> !trap_req_o);
  // R10
  zero_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !fault && count_i == '0 |=> res_hi_o == $past(op_hi_i) && !ovf_o && !trap_req_o);
  // R3
  sla_sign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !rot_i && !dbl_i && kind_i == 2'b10 |=> res_hi_o[WORD_W-1] == $past(op_hi_i[WORD_W-1]));
endmodule

bind shx_unit shx_unit_chk #(.WORD_W(WORD_W), .CNT_W(CNT_W)) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .valid_i      (valid_i),
  .kind_i       (kind_i),
  .count_i      (count_i),
  .dbl_i        (dbl_i),
  .rot_i        (rot_i),
  .reg_odd_i    (reg_odd_i),
  .aexp_en_i    (aexp_en_i),
  .cc_i         (cc_i),
  .op_hi_i      (op_hi_i),
  .res_hi_o     (res_hi_o),
  .res_lo_o     (res_lo_o),
  .cc_o         (cc_o),
  .ovf_o        (ovf_o),
  .trap_req_o   (trap_req_o),
  .trap_cause_o (trap_cause_o),
  .done_o       (done_o)
);

// File: tb/shx_unit_tb_top.sv
`timescale 1ns/1ps
module shx_unit_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [1:0]  kind_i = '0;
  logic [4:0]  count_i = '0;
  logic        dbl_i = 1'b0, rot_i = 1'b0, reg_odd_i = 1'b0, aexp_en_i = 1'b0;
  logic [3:0]  cc_i = '0;
  logic [31:0] op_hi_i = '0, op_lo_i = '0;
  logic [31:0] res_hi_o, res_lo_o;
  logic [3:0]  cc_o;
  logic        ovf_o, trap_req_o, done_o;
  logic [1:0]  trap_cause_o;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;
  logic [31:0] last_hi = '0, last_lo = '0;
  logic [3:0]  last_cc = '0;

  always #2.5 clk_i = ~clk_i;

  shx_unit dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .kind_i(kind_i),
    .count_i(count_i), .dbl_i(dbl_i), .rot_i(rot_i), .reg_odd_i(reg_odd_i),
    .aexp_en_i(aexp_en_i), .cc_i(cc_i), .op_hi_i(op_hi_i), .op_lo_i(op_lo_i),
    .res_hi_o(res_hi_o), .res_lo_o(res_lo_o), .cc_o(cc_o), .ovf_o(ovf_o),
    .trap_req_o(trap_req_o), .trap_cause_o(trap_cause_o), .done_o(done_o)
  );

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // one-position-at-a-time reference of the shift rules
  task automatic model(input logic [1:0] k, input int cnt, input bit dbl, input bit rot,
                       input logic [31:0] hi, input logic [31:0] lo,
                       output logic [31:0] ehi, output logic [31:0] elo, output bit eovf);
    logic [63:0] v;
    logic [31:0] w;
    int wd;
    bit s;
    eovf = 0;
    if (rot) begin
      w = hi;
      for (int i = 0; i < cnt; i++)
        w = k[1] ? {w[30:0], w[31]} : {w[0], w[31:1]};
      ehi = w; elo = '0;
      return;
    end
    wd = dbl ? 64 : 32;
    v  = dbl ? {hi, lo} : {32'h0, hi};
    s  = v[wd-1];
    for (int i = 0; i < cnt; i++) begin
      case (k)
        2'b00: begin v = v >> 1; v[wd-1] = s; end
        2'b01: v = v >> 1;
        2'b10: begin v = v << 1; if (!dbl) v[63:32] = '0; if (v[wd-1] != s) eovf = 1; end
        default: begin v = v << 1; if (!dbl) v[63:32] = '0; end
      endcase
    end
    if (k == 2'b10) v[wd-1] = s;
    if (dbl) begin ehi = v[63:32]; elo = v[31:0]; end
    else begin ehi = v[31:0]; elo = '0; end
  endtask

  task automatic do_op(input string req, input logic [1:0] k, input int cnt, input bit dbl,
                       input bit rot, input bit odd, input bit aen, input logic [3:0] cc,
                       input logic [31:0] hi, input logic [31:0] lo);
    logic [31:0] ehi, elo;
    logic [3:0]  ecc;
    logic [1:0]  ecause;
    bit eovf, fault;
    model(k, cnt, dbl, rot, hi, lo, ehi, elo, eovf);
    fault = dbl && !rot && odd;
    if (fault) begin
      ehi = last_hi; elo = last_lo; ecc = last_cc; eovf = 0; ecause = 2'b10;
    end else begin
      ecc = (!rot && k == 2'b10) ? {eovf, 3'b000} : cc;
      ecause = (eovf && aen) ? 2'b01 : 2'b00;
    end
    @(negedge clk_i);
    valid_i = 1; kind_i = k; count_i = 5'(cnt); dbl_i = dbl; rot_i = rot;
    reg_odd_i = odd; aexp_en_i = aen; cc_i = cc; op_hi_i = hi; op_lo_i = lo;
    @(negedge clk_i);
    valid_i = 0;
    chk(req, "done", 64'(done_o), 64'(1'b1));
    chk(req, "res_hi", 64'(res_hi_o), 64'(ehi));
    chk(req, "res_lo", 64'(res_lo_o), 64'(elo));
    chk(req, "cc", 64'(cc_o), 64'(ecc));
    chk(req, "ovf", 64'(ovf_o), 64'(eovf));
    chk(req, "trap_req", 64'(trap_req_o), 64'(ecause != 2'b00));
    chk(req, "cause", 64'(trap_cause_o), 64'(ecause));
    last_hi = ehi; last_lo = elo; last_cc = ecc;
  endtask

  task automatic t_reset;
    chk("R11", "reset res_hi", 64'(res_hi_o), 64'h0);
    chk("R11", "reset cc", 64'(cc_o), 64'h0);
    chk("R11", "reset trap", 64'({trap_req_o, trap_cause_o, ovf_o, done_o}), 64'h0);
  endtask

  task automatic t_right;
    // R2 R1 R9: arithmetic right, single, negative and positive
    do_op("R2", 2'b00, 4, 0, 0, 0, 1, 4'b0110, 32'h8000_0010, 32'h0);
    do_op("R2", 2'b00, 31, 0, 0, 0, 1, 4'b1001, 32'h7FFF_FFFF, 32'h0);
    do_op("R9", 2'b01, 8, 0, 0, 0, 1, 4'b0101, 32'hF000_00FF, 32'h0);
  endtask

  task automatic t_left;
    do_op("R4", 2'b10, 4, 0, 0, 0, 1, 4'b1111, 32'h0000_0003, 32'h0);
    do_op("R3", 2'b10, 1, 0, 0, 0, 0, 4'b0000, 32'h4000_0001, 32'h0);
    do_op("R5", 2'b10, 1, 0, 0, 0, 1, 4'b0000, 32'h4000_0001, 32'h0);
    do_op("R3", 2'b10, 1, 0, 0, 0, 1, 4'b0110, 32'hC000_0000, 32'h0);
    do_op("R3", 2'b10, 31, 0, 0, 0, 1, 4'b0000, 32'hFFFF_FFFE, 32'h0);
    do_op("R1", 2'b11, 12, 0, 0, 0, 1, 4'b0011, 32'h8123_4567, 32'h0);
  endtask

  task automatic t_pair;
    do_op("R6", 2'b00, 8, 1, 0, 0, 0, 4'b0100, 32'h8000_0000, 32'h0000_0001);
    do_op("R6", 2'b01, 20, 1, 0, 0, 0, 4'b0010, 32'h0012_3456, 32'h789A_BCDE);
    do_op("R6", 2'b11, 16, 1, 0, 0, 0, 4'b1000, 32'h0000_ABCD, 32'h1234_5678);
    do_op("R5", 2'b10, 2, 1, 0, 0, 1, 4'b0000, 32'h2000_0000, 32'h8000_0001);
    do_op("R6", 2'b10, 3, 1, 0, 0, 1, 4'b0000, 32'hF000_0000, 32'hE000_0000);
  endtask

  task automatic t_odd;
    do_op("R7", 2'b01, 4, 0, 0, 0, 0, 4'b0101, 32'hDEAD_BEEF, 32'h0);
    do_op("R7", 2'b11, 5, 1, 0, 1, 1, 4'b1010, 32'h1111_1111, 32'h2222_2222);
  endtask

  task automatic t_rot;
    do_op("R8", 2'b10, 4, 0, 1, 0, 1, 4'b0110, 32'h8000_0001, 32'hFFFF_FFFF);
    do_op("R8", 2'b00, 8, 1, 1, 1, 1, 4'b1001, 32'h1234_56FF, 32'hFFFF_FFFF);
    do_op("R8", 2'b01, 31, 0, 1, 0, 0, 4'b0000, 32'h0000_0001, 32'h0);
  endtask

  task automatic t_zero;
    do_op("R10", 2'b10, 0, 0, 0, 0, 1, 4'b0111, 32'hA000_0000, 32'h0);
    do_op("R10", 2'b00, 0, 1, 0, 0, 1, 4'b0001, 32'h8765_4321, 32'h0FED_CBA9);
    do_op("R10", 2'b11, 0, 0, 1, 0, 1, 4'b0010, 32'h5555_AAAA, 32'h0);
  endtask

  task automatic t_hold;
    do_op("R11", 2'b10, 1, 0, 0, 0, 1, 4'b0000, 32'h4000_0000, 32'h0);
    @(negedge clk_i);
    op_hi_i = 32'h0; cc_i = 4'b1111; aexp_en_i = 0; kind_i = 2'b01;
    repeat (3) @(negedge clk_i);
    chk("R11", "done idle", 64'(done_o), 64'h0);
    chk("R11", "held res", 64'(res_hi_o), 64'(last_hi));
    chk("R11", "held cc", 64'(cc_o), 64'(last_cc));
    chk("R11", "held trap", 64'({trap_req_o, trap_cause_o}), 64'(3'b101));
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    #12;
    t_reset();
    rst_ni = 1;
    t_right();
    t_left();
    t_pair();
    t_odd();
    t_rot();
    t_zero();
    t_hold();
    finish_run();
  end
endmodule